// File: doc/BRIEF.md
# Four-Player Quiz Buzzer Controller

This block referees a four-contestant quiz round. Each contestant has one push button. The first contestant whose press is seen gets the round. That contestant's lamp lights, a short buzzer pulse fires, and every other button is then ignored until the round is cleared. The winning contestant is also reported as a small binary code, which a display stage can show.

Once the round is locked, a two-digit BCD answer timer counts down from 99 toward 00. It steps once per one-second tick. When it reaches 00 it raises a timeout alarm and holds there.

A single active-low clear input serves as both the block reset and the round clear. Clear takes effect asynchronously, and its release is synchronized to the clock. Seven-segment decoding, digit scanning and driving the sound transducer are left to the stages that follow this block.

Top module: `quiz_buzzer_ctrl`

## Requirements
- R1: While `clr_n` is low, all lamps, `locked`, `press_beep` and `time_alarm` read 0, `winner_code` reads 4'b1111, and the digits read 9 and 9.
- R2: A button rising edge lights only the lamp of that contestant, where `btn[i]` maps to `lamp[i]`, and sets `locked`. This is visible within six clock cycles of the press.
- R3: Once `locked` is high, no later press changes the lamps or `winner_code` until clear.
- R4: If several contestants' press edges land in the same cycle, the lowest index wins. Exactly one lamp is ever lit.
- R5: `winner_code` is 1, 2, 3 or 4 for `btn[0]`, `btn[1]`, `btn[2]` or `btn[3]` respectively, and 4'b1111 while no contestant has won.
- R6: `press_beep` goes high once, at the lock, for exactly `BEEP_CYCLES` clock cycles.
- R7: While locked, each cycle with `sec_tick` high decrements `digit_lo`. When `digit_lo` is 0 and `digit_hi` is not, `digit_lo` reloads to 9 and `digit_hi` drops by one. Cycles without a tick leave the digits unchanged.
- R8: While unlocked, the digits hold at 99, `sec_tick` has no effect, and `time_alarm` stays low.
- R9: The tick that brings the digits to 00 raises `time_alarm` on the same edge. The digits then hold at 00 and the alarm stays high until clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| clr_n | input | 1 | Active-low clear/reset; asynchronous assert, synchronized release |
| sec_tick | input | 1 | One-cycle pulse per second of answer time |
| btn | input | 4 | Contestant buttons, active high, asynchronous |
| lamp | output | 4 | One-hot lamp of the winning contestant |
| winner_code | output | 4 | Winner number 1 to 4, or 4'b1111 for none |
| locked | output | 1 | Round taken; further presses ignored |
| press_beep | output | 1 | Buzzer pulse at the moment of lock |
| digit_hi | output | 4 | BCD tens digit of the remaining time |
| digit_lo | output | 4 | BCD units digit of the remaining time |
| time_alarm | output | 1 | Answer time exhausted |

## Verification
The bench presses each contestant alone and then in simultaneous groups. A wrong priority order would show up as the wrong lamp or code. After each lock, the bench presses the rival buttons, so a design that kept listening would move the lamp.

The countdown is checked around the digit-borrow points 98, 90, 89 and 01, at 00, and on one tick past 00. A borrow bug, an early or late alarm, or a counter that wraps past 00 would each give a wrong digit pair. Ticks sent before any press must leave the digits at 99. The buzzer pulse length is counted in cycles, which catches a pulse that is off by one or that restarts.

// File: rtl/qb_pkg.sv
package qb_pkg;
  localparam int unsigned DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] bcd_t;
  localparam bcd_t BCD_NINE = bcd_t'(9);
  localparam bcd_t BCD_ZERO = bcd_t'(0);
endpackage

// File: rtl/qb_rst_sync.sv
module qb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/qb_btn_sync.sv
module qb_btn_sync #(
  parameter int unsigned N_BTN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_BTN-1:0] btn_raw,
  output logic [N_BTN-1:0] press_edge
);
  for (genvar g = 0; g < N_BTN; g++) begin : g_btn
    logic meta_q, sync_q, last_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        last_q <= 1'b0;
      end else begin
        meta_q <= btn_raw[g];
        sync_q <= meta_q;
        last_q <= sync_q;
      end
    end

    assign press_edge[g] = sync_q & ~last_q;
  end
endmodule

// File: rtl/qb_arbiter.sv
module qb_arbiter #(
  parameter int unsigned N_BTN       = 4,
  parameter int unsigned CODE_W      = 4,
  parameter int unsigned BEEP_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_BTN-1:0]  press_edge,
  output logic [N_BTN-1:0]  lamp,
  output logic [CODE_W-1:0] winner_code,
  output logic              locked,
  output logic              beep
);
  localparam int unsigned BEEP_W = $clog2(BEEP_CYCLES + 1);
  localparam logic [CODE_W-1:0] NO_WINNER = '1;
  localparam logic [BEEP_W-1:0] BEEP_LOAD = BEEP_W'(BEEP_CYCLES);

  logic [N_BTN-1:0]  lamp_q, lamp_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              lock_q, lock_d;
  logic [BEEP_W-1:0] beep_q, beep_d;
  logic [CODE_W-1:0] pick_code;
  logic [N_BTN-1:0]  pick_onehot;

  always_comb begin
    pick_code = NO_WINNER;
    for (int i = N_BTN - 1; i >= 0; i--) begin
      if (press_edge[i]) pick_code = CODE_W'(i + 1);
    end
    pick_onehot = press_edge & ~(press_edge - 1'b1);
  end

  always_comb begin
    lamp_d = lamp_q;
    code_d = code_q;
    lock_d = lock_q;
    beep_d = beep_q;
    if (beep_q != '0) beep_d = beep_q - 1'b1;
    if (!lock_q && (press_edge != '0)) begin
      lock_d = 1'b1;
      lamp_d = pick_onehot;
      code_d = pick_code;
      beep_d = BEEP_LOAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lamp_q <= '0;
      code_q <= NO_WINNER;
      lock_q <= 1'b0;
      beep_q <= '0;
    end else begin
      lamp_q <= lamp_d;
      code_q <= code_d;
      lock_q <= lock_d;
      beep_q <= beep_d;
    end
  end

  assign lamp        = lamp_q;
  assign winner_code = code_q;
  assign locked      = lock_q;
  assign beep        = (beep_q != '0);

  // R4
  one_lamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lamp_q) && (lock_q == (lamp_q != '0)));
  // R3
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> (lock_q && $stable(lamp_q) && $stable(code_q)));
  // R5
  idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_q |-> (code_q == NO_WINNER));
  // R6
  beep_in_round_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beep |-> lock_q);
  // R6
  beep_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> beep);
endmodule

// File: rtl/qb_bcd_timer.sv
module qb_bcd_timer
  import qb_pkg::*;
#(
  parameter bcd_t START_HI = BCD_NINE,
  parameter bcd_t START_LO = BCD_NINE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic tick,
  output bcd_t hi,
  output bcd_t lo,
  output logic alarm
);
  bcd_t hi_q, hi_d, lo_q, lo_d;
  logic al_q, al_d;

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    al_d = al_q;
    if (!run_en) begin
      hi_d = START_HI;
      lo_d = START_LO;
      al_d = 1'b0;
    end else if (tick) begin
      if (lo_q == BCD_ZERO && hi_q == BCD_ZERO) begin
        al_d = 1'b1;
      end else if (lo_q == BCD_ZERO) begin
        lo_d = BCD_NINE;
        hi_d = hi_q - 1'b1;
      end else begin
        lo_d = lo_q - 1'b1;
      end
      if (lo_d == BCD_ZERO && hi_d == BCD_ZERO) al_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= START_HI;
      lo_q <= START_LO;
      al_q <= 1'b0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
      al_q <= al_d;
    end
  end

  assign hi    = hi_q;
  assign lo    = lo_q;
  assign alarm = al_q;

  // R7
  bcd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_q <= BCD_NINE) && (hi_q <= BCD_NINE));
  // R7
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !tick) |=> ($stable(hi_q) && $stable(lo_q)));
  // R8
  idle_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (hi_q == START_HI && lo_q == START_LO && !al_q));
  // R9
  alarm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    al_q |-> (hi_q == BCD_ZERO && lo_q == BCD_ZERO));
  // R9
  alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (al_q && run_en) |=> al_q);
endmodule

// File: rtl/quiz_buzzer_ctrl.sv
module quiz_buzzer_ctrl
  import qb_pkg::*;
#(
  parameter int unsigned N_BTN       = 4,
  parameter int unsigned CODE_W      = 4,
  parameter int unsigned BEEP_CYCLES = 8,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              sec_tick,
  input  logic [N_BTN-1:0]  btn,
  output logic [N_BTN-1:0]  lamp,
  output logic [CODE_W-1:0] winner_code,
  output logic              locked,
  output logic              press_beep,
  output logic [3:0]        digit_hi,
  output logic [3:0]        digit_lo,
  output logic              time_alarm
);
  logic             rst_n;
  logic [N_BTN-1:0] press_edge;
  logic             lock_w;
  bcd_t             hi_w, lo_w;

  qb_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .clr_n(clr_n), .rst_n(rst_n)
  );

  qb_btn_sync #(.N_BTN(N_BTN)) u_sync (
    .clk(clk), .rst_n(rst_n), .btn_raw(btn), .press_edge(press_edge)
  );

  qb_arbiter #(.N_BTN(N_BTN), .CODE_W(CODE_W), .BEEP_CYCLES(BEEP_CYCLES)) u_arb (
    .clk(clk), .rst_n(rst_n), .press_edge(press_edge),
    .lamp(lamp), .winner_code(winner_code), .locked(lock_w), .beep(press_beep)
  );

  qb_bcd_timer u_tmr (
    .clk(clk), .rst_n(rst_n), .run_en(lock_w), .tick(sec_tick),
    .hi(hi_w), .lo(lo_w), .alarm(time_alarm)
  );

  assign locked   = lock_w;
  assign digit_hi = hi_w;
  assign digit_lo = lo_w;
endmodule

// File: tb/sim_quiz_buzzer_ctrl.sv
module sim_quiz_buzzer_ctrl;
  localparam int BEEP = 5;
  localparam int NV = 7;
  // {first press, later press, expected lamp, expected code}
  localparam logic [15:0] VEC [NV] = '{
    16'b0001_1110_0001_0001,
    16'b0010_0001_0010_0010,
    16'b0100_1011_0100_0011,
    16'b1000_0111_1000_0100,
    16'b0110_1001_0010_0010,
    16'b1100_0011_0100_0011,
    16'b1111_0000_0001_0001
  };

  logic clk = 1'b0;
  logic clr_n = 1'b0;
  logic sec_tick = 1'b0;
  logic [3:0] btn = '0;
  logic [3:0] lamp, winner_code, digit_hi, digit_lo;
  logic locked, press_beep, time_alarm;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  quiz_buzzer_ctrl #(.BEEP_CYCLES(BEEP)) u0 (
    .clk(clk), .clr_n(clr_n), .sec_tick(sec_tick), .btn(btn),
    .lamp(lamp), .winner_code(winner_code), .locked(locked),
    .press_beep(press_beep), .digit_hi(digit_hi), .digit_lo(digit_lo),
    .time_alarm(time_alarm)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_clear();
    @(negedge clk) clr_n = 1'b0;
    repeat (2) @(negedge clk);
    clr_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic press(input logic [3:0] p);
    @(negedge clk) btn = p;
    repeat (3) @(negedge clk);
    btn = '0;
    repeat (4) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sec_tick = 1'b1;
      @(negedge clk) sec_tick = 1'b0;
    end
  endtask

  task automatic chk_digits(input string req, input int hi, input int lo, input int al);
    chk(req, {digit_hi, digit_lo}, hi * 16 + lo);
    chk(req, time_alarm, al);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset state while clear held
    repeat (3) @(negedge clk);
    chk("R1 lamp", lamp, 0);
    chk("R1 code", winner_code, 4'hF);
    chk("R1 lock/beep", {locked, press_beep}, 0);
    chk_digits("R1 digits", 9, 9, 0);

    // R2 R3 R4 R5 table walk
    for (int v = 0; v < NV; v++) begin
      do_clear();
      chk("R5 idle code", winner_code, 4'hF);
      press(VEC[v][15:12]);
      chk("R2 R4 lamp", lamp, VEC[v][7:4]);
      chk("R5 code", winner_code, VEC[v][3:0]);
      chk("R2 locked", locked, 1);
      press(VEC[v][11:8]);
      chk("R3 lamp after rival", lamp, VEC[v][7:4]);
      chk("R3 code after rival", winner_code, VEC[v][3:0]);
    end

    // R8 ticks ignored while unlocked
    do_clear();
    ticks(3);
    chk_digits("R8 unlocked ticks", 9, 9, 0);

    // R6 beep pulse length
    begin
      int hi_cnt = 0;
      @(negedge clk) btn = 4'b0100;
      for (int c = 0; c < 30; c++) begin
        @(negedge clk);
        if (press_beep) hi_cnt++;
        if (c == 3) btn = '0;
      end
      chk("R6 beep cycles", hi_cnt, BEEP);
      chk("R5 code p3", winner_code, 3);
    end

    // R7 countdown and borrows
    repeat (3) @(negedge clk);
    chk_digits("R7 no tick", 9, 9, 0);
    ticks(1);
    chk_digits("R7 first step", 9, 8, 0);
    ticks(8);
    chk_digits("R7 at 90", 9, 0, 0);
    ticks(1);
    chk_digits("R7 borrow 89", 8, 9, 0);
    ticks(88);
    chk_digits("R7 at 01", 0, 1, 0);
    ticks(1);
    chk_digits("R9 reach 00", 0, 0, 1);
    ticks(2);
    chk_digits("R9 hold 00", 0, 0, 1);

    // R1 clear mid-round, asynchronous
    @(negedge clk) clr_n = 1'b0;
    #1;
    chk("R1 clear lamp", lamp, 0);
    chk("R1 clear code", winner_code, 4'hF);
    chk("R1 clear lock", locked, 0);
    chk_digits("R1 clear digits", 9, 9, 0);
    @(negedge clk) clr_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 new round after clear
    press(4'b1000);
    chk("R2 new round lamp", lamp, 4'b1000);
    chk("R5 new round code", winner_code, 4);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule